// File: doc/BRIEF.md
# Flash Array Control Register with Sticky Write-Lock

This block is the single control register in front of an embedded flash array. It holds four software-visible fields: an array halt bit, an unlock bit for the protected configuration group, a sticky force-censorship bit, and a shadow-row select bit. A write is qualified field by field against the program/erase status, the censorship-control input and the debug-mode flag, so that some fields ignore a write while others in the same write take effect. Each decision uses the register state as it was before the write.

Around the fields the block produces the signals the array and sequencer need. It gates program/erase requests while the array is halted. It holds the array-ready flag low for a recovery time, counted in clock cycles, after the halt bit is cleared. It emits a one-cycle reset to the page-buffer monitor whenever the shadow-row select changes. It also folds the access address down to its low bits while the shadow row is selected.

Field layout of `wr_data` and `rd_data`: bit 0 halt, bit 1 unlock (1 = unlocked), bit 2 force-censorship, bit 3 shadow select. All higher bits are reserved.

Top module: `flash_ctl_reg`

## Requirements
- R1: After reset `rd_data` is 8'h03 (halt=1, unlock=1, force-censorship=0, shadow=0). `cfg_locked`, `array_ready` and `pbuf_reset` are 0.
- R2: A write to the halt bit (bit 0) is ignored while `pe_busy` is 1. Otherwise it is accepted, including while the array is halted, so the halt bit can always be cleared.
- R3: `pe_grant` is 1 only when `pe_req` is 1 and the halt bit is 0. A request made while halted is not granted.
- R4: `array_ready` is 0 while halted. It rises exactly RECOV_CYC clock edges after the halt bit falls, where RECOV_CYC = CLK_MHZ*RECOV_NS/1000 (50 with the defaults).
- R5: Writing 0 to the unlock bit (bit 1) takes effect only if `cens_ctl` is 0 and no lock has yet been taken since reset. A second lock in the same reset period is ignored.
- R6: Once locked, a write of 1 to the unlock bit is ignored unless `dbg_mode` is 1 and `cens_ctl` is 0.
- R7: `cfg_locked` is 1 exactly while the unlock bit is 0. While locked, a write of 1 to the force-censorship bit is ignored.
- R8: A write of 1 to the force-censorship bit (bit 2) is ignored when `cens_ctl` is 1. Once set, the bit stays 1 until reset, and a write of 0 has no effect.
- R9: A write to the shadow select bit (bit 3) is ignored while programming is in progress (`pe_busy`=1 and `prog_en`=0). It is accepted during erase (`prog_en`=1) and when idle.
- R10: `pbuf_reset` is 1 for exactly the one cycle in which the shadow select bit has just changed. While shadow is selected, `arr_addr` keeps only the low SHADOW_W bits of `acc_addr` and zeroes the rest; otherwise it equals `acc_addr`.
- R11: Reserved bits (7:4) read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Register write data |
| rd_data | output | DATA_W | Register read data |
| pe_busy | input | 1 | Program or erase operation active |
| prog_en | input | 1 | Program-enable status (0 with pe_busy means programming) |
| pe_req | input | 1 | Request to start program/erase |
| pe_grant | output | 1 | Request allowed (array not halted) |
| dbg_mode | input | 1 | Debug mode flag |
| cens_ctl | input | 1 | Censorship-control input |
| acc_addr | input | ADDR_W | Array access address |
| arr_addr | output | ADDR_W | Address passed to the array decode |
| halt | output | 1 | Halt field |
| unlocked | output | 1 | Unlock field |
| force_cens | output | 1 | Force-censorship field |
| shadow_en | output | 1 | Shadow select field |
| cfg_locked | output | 1 | Protected configuration group is locked |
| array_ready | output | 1 | Array may be accessed |
| pbuf_reset | output | 1 | One-cycle page-buffer monitor reset |

## Verification
Every field, `cfg_locked` and `pbuf_reset` are registered, so they change on the first clock edge after the write strobe. The driver pushes each expected register image into a queue one edge after it drives a write, and the monitor compares it on the falling edge that follows. `array_ready` is sampled once RECOV_CYC-1 edges after the halt bit falls, where it must still be low, and once more one edge later, where it must be high. `pe_grant` and `arr_addr` are combinational and are checked within the same cycle as the stimulus.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
    localparam int NUM_FIELDS = 4;
    localparam int HALT_BIT   = 0;
    localparam int UNLOCK_BIT = 1;
    localparam int FORCE_BIT  = 2;
    localparam int SHADOW_BIT = 3;

    typedef struct packed {
        logic halt;
        logic unlock;
        logic force_cens;
        logic shadow_en;
        logic lock_used;
        logic pbuf;
    } fcr_state_t;
endpackage

// File: rtl/fcr_fields.sv
module fcr_fields
    import flash_ctl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [NUM_FIELDS-1:0] wr_bits,
    input  logic                  pe_busy,
    input  logic                  prog_en,
    input  logic                  dbg_mode,
    input  logic                  cens_ctl,
    output logic                  halt_o,
    output logic                  unlock_o,
    output logic                  force_o,
    output logic                  shadow_o,
    output logic                  pbuf_o
);
    fcr_state_t st_d, st_q;
    logic       programming;

    assign programming = pe_busy && !prog_en;

    always_comb begin
        st_d      = st_q;
        st_d.pbuf = 1'b0;
        if (wr_en) begin
            if (!pe_busy) begin
                st_d.halt = wr_bits[HALT_BIT];
            end
            if (st_q.unlock && !wr_bits[UNLOCK_BIT] && !st_q.lock_used && !cens_ctl) begin
                st_d.unlock    = 1'b0;
                st_d.lock_used = 1'b1;
            end else if (!st_q.unlock && wr_bits[UNLOCK_BIT] && dbg_mode && !cens_ctl) begin
                st_d.unlock = 1'b1;
            end
            if (st_q.unlock && !cens_ctl && wr_bits[FORCE_BIT]) begin
                st_d.force_cens = 1'b1;
            end
            if (!programming) begin
                st_d.shadow_en = wr_bits[SHADOW_BIT];
            end
        end
        st_d.pbuf = (st_d.shadow_en != st_q.shadow_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{halt: 1'b1, unlock: 1'b1, force_cens: 1'b0,
                      shadow_en: 1'b0, lock_used: 1'b0, pbuf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign halt_o   = st_q.halt;
    assign unlock_o = st_q.unlock;
    assign force_o  = st_q.force_cens;
    assign shadow_o = st_q.shadow_en;
    assign pbuf_o   = st_q.pbuf;

    AST_HALT_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pe_busy) |=> $stable(halt_o)); // R2
    AST_LOCK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock_used && unlock_o) |=> unlock_o); // R5
    AST_UNLOCK_DEBUG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlock_o && !(wr_en && dbg_mode && !cens_ctl)) |=> !unlock_o); // R6
    AST_FORCE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        force_o |=> force_o); // R8
    AST_FORCE_CENS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_o && cens_ctl) |=> !force_o); // R8
    AST_SHADOW_PROG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && programming) |=> $stable(shadow_o)); // R9
endmodule

// File: rtl/fcr_wake_timer.sv
module fcr_wake_timer #(
    parameter int RECOV_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    output logic ready
);
    localparam int CNT_W = (RECOV_CYC < 1) ? 1 : $clog2(RECOV_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RECOV_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (halt) begin
            cnt_d = '0;
        end else if (cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign ready = !halt && (cnt_q == LIMIT);

    AST_NOT_READY_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(halt) && RECOV_CYC > 0) |-> !ready); // R4
    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !halt) |=> (ready || halt)); // R4
endmodule

// File: rtl/fcr_addr_map.sv
module fcr_addr_map #(
    parameter int ADDR_W   = 12,
    parameter int SHADOW_W = 6
) (
    input  logic              shadow_en,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i < SHADOW_W) begin : g_low
            assign addr_out[i] = addr_in[i];
        end else begin : g_high
            assign addr_out[i] = addr_in[i] & ~shadow_en;
        end
    end
endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
    import flash_ctl_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 12,
    parameter int SHADOW_W = 6,
    parameter int CLK_MHZ  = 50,
    parameter int RECOV_NS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pe_busy,
    input  logic              prog_en,
    input  logic              pe_req,
    output logic              pe_grant,
    input  logic              dbg_mode,
    input  logic              cens_ctl,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              halt,
    output logic              unlocked,
    output logic              force_cens,
    output logic              shadow_en,
    output logic              cfg_locked,
    output logic              array_ready,
    output logic              pbuf_reset
);
    localparam int RECOV_CYC = (CLK_MHZ * RECOV_NS) / 1000;

    logic [NUM_FIELDS-1:0] field_vec;
    logic                  rsvd_unused;

    assign rsvd_unused = ^wr_data[DATA_W-1:NUM_FIELDS];

    fcr_fields u_fields (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_bits  (wr_data[NUM_FIELDS-1:0]),
        .pe_busy  (pe_busy),
        .prog_en  (prog_en),
        .dbg_mode (dbg_mode),
        .cens_ctl (cens_ctl),
        .halt_o   (halt),
        .unlock_o (unlocked),
        .force_o  (force_cens),
        .shadow_o (shadow_en),
        .pbuf_o   (pbuf_reset)
    );

    fcr_wake_timer #(.RECOV_CYC(RECOV_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .halt  (halt),
        .ready (array_ready)
    );

    fcr_addr_map #(.ADDR_W(ADDR_W), .SHADOW_W(SHADOW_W)) u_amap (
        .shadow_en (shadow_en),
        .addr_in   (acc_addr),
        .addr_out  (arr_addr)
    );

    assign field_vec[HALT_BIT]   = halt;
    assign field_vec[UNLOCK_BIT] = unlocked;
    assign field_vec[FORCE_BIT]  = force_cens;
    assign field_vec[SHADOW_BIT] = shadow_en;

    for (genvar i = 0; i < DATA_W; i++) begin : g_rd
        if (i < NUM_FIELDS) begin : g_fld
            assign rd_data[i] = field_vec[i];
        end else begin : g_rsvd
            assign rd_data[i] = 1'b0;
        end
    end

    assign cfg_locked = !unlocked;
    assign pe_grant   = pe_req && !halt;

    AST_GRANT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        pe_grant |-> !halt); // R3
    AST_PBUF_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pbuf_reset |-> (shadow_en != $past(shadow_en))); // R10
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:NUM_FIELDS] == '0); // R11
endmodule

// File: tb/flash_ctl_reg_tb.sv
module flash_ctl_reg_tb;
    localparam int  CLK_PERIOD = 10;
    localparam int  RECOV      = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        pe_busy = 1'b0, prog_en = 1'b0, pe_req = 1'b0;
    logic        pe_grant;
    logic        dbg_mode = 1'b0, cens_ctl = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [11:0] arr_addr;
    logic        halt, unlocked, force_cens, shadow_en;
    logic        cfg_locked, array_ready, pbuf_reset;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [7:0] rd;
        logic       lk;
        logic       pb;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_ctl_reg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pe_busy(pe_busy), .prog_en(prog_en),
        .pe_req(pe_req), .pe_grant(pe_grant), .dbg_mode(dbg_mode),
        .cens_ctl(cens_ctl), .acc_addr(acc_addr), .arr_addr(arr_addr),
        .halt(halt), .unlocked(unlocked), .force_cens(force_cens),
        .shadow_en(shadow_en), .cfg_locked(cfg_locked),
        .array_ready(array_ready), .pbuf_reset(pbuf_reset)
    );

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares the registered image one edge after each push.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " rd_data"}, {4'h0, rd_data}, {4'h0, e.rd});
            check({e.tag, " cfg_locked"}, {11'h0, cfg_locked}, {11'h0, e.lk});
            check({e.tag, " pbuf_reset"}, {11'h0, pbuf_reset}, {11'h0, e.pb});
        end
    end

    // Driver: one write (or idle) cycle, then queue the expected result.
    task automatic apply(input logic we, input logic [7:0] d, input logic [7:0] rd,
                         input logic lk, input logic pb, input string tag);
        exp_t e;
        @(negedge clk);
        wr_en   = we;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        e.rd = rd; e.lk = lk; e.pb = pb; e.tag = tag;
        exp_q.push_back(e);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 rd_data", {4'h0, rd_data}, 12'h003);
        check("R1 cfg_locked", {11'h0, cfg_locked}, 12'h0);
        check("R1 array_ready", {11'h0, array_ready}, 12'h0);
        check("R1 pbuf_reset", {11'h0, pbuf_reset}, 12'h0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(1'b0, 8'h00, 8'h03, 1'b0, 1'b0, "R1 idle");

        // R3 request while halted
        pe_req = 1'b1;
        #1 check("R3 grant while halted", {11'h0, pe_grant}, 12'h0);

        // R2 halt clear ignored while busy
        pe_busy = 1'b1; prog_en = 1'b1;
        apply(1'b1, 8'h02, 8'h03, 1'b0, 1'b0, "R2 busy");
        pe_busy = 1'b0;
        apply(1'b1, 8'h02, 8'h02, 1'b0, 1'b0, "R2 clear halt");
        // R4 recovery window: halt fell at the edge just passed
        check("R4 not ready on wake", {11'h0, array_ready}, 12'h0);
        #1 check("R3 grant running", {11'h0, pe_grant}, 12'h1);
        pe_req = 1'b0;
        repeat (RECOV - 1) @(posedge clk);
        #1 check("R4 still low", {11'h0, array_ready}, 12'h0);
        @(posedge clk);
        #1 check("R4 ready", {11'h0, array_ready}, 12'h1);

        // R11 reserved bits and R8 censorship control
        cens_ctl = 1'b1;
        apply(1'b1, 8'hF6, 8'h02, 1'b0, 1'b0, "R8 R11 cens blocks force");
        apply(1'b1, 8'h00, 8'h02, 1'b0, 1'b0, "R5 cens blocks lock");
        cens_ctl = 1'b0;
        apply(1'b1, 8'h00, 8'h00, 1'b1, 1'b0, "R5 R7 lock taken");
        apply(1'b1, 8'h06, 8'h00, 1'b1, 1'b0, "R6 R7 locked ignores");
        dbg_mode = 1'b1; cens_ctl = 1'b1;
        apply(1'b1, 8'h02, 8'h00, 1'b1, 1'b0, "R6 debug with cens");
        cens_ctl = 1'b0;
        apply(1'b1, 8'h02, 8'h02, 1'b0, 1'b0, "R6 debug unlock");
        dbg_mode = 1'b0;
        apply(1'b1, 8'h00, 8'h02, 1'b0, 1'b0, "R5 second lock");
        apply(1'b1, 8'hF6, 8'h06, 1'b0, 1'b0, "R8 R11 force set");
        apply(1'b1, 8'h02, 8'h06, 1'b0, 1'b0, "R8 force sticky");

        // R9 shadow select vs programming
        pe_busy = 1'b1; prog_en = 1'b0;
        apply(1'b1, 8'h0E, 8'h06, 1'b0, 1'b0, "R9 programming blocks");
        prog_en = 1'b1;
        apply(1'b1, 8'h0E, 8'h0E, 1'b0, 1'b1, "R9 R10 erase allows");
        apply(1'b0, 8'h00, 8'h0E, 1'b0, 1'b0, "R10 pulse one cycle");
        acc_addr = 12'hABC;
        #1 check("R10 shadow address", arr_addr, 12'h03C);
        pe_busy = 1'b0;
        apply(1'b1, 8'h0E, 8'h0E, 1'b0, 1'b0, "R10 no change no pulse");
        apply(1'b1, 8'h06, 8'h06, 1'b0, 1'b1, "R10 shadow off pulse");
        #1 check("R10 normal address", arr_addr, 12'hABC);

        // R2 halt set while busy ignored, then accepted
        pe_busy = 1'b1;
        apply(1'b1, 8'h07, 8'h06, 1'b0, 1'b0, "R2 set busy");
        pe_busy = 1'b0;
        apply(1'b1, 8'h07, 8'h07, 1'b0, 1'b0, "R2 set halt");
        check("R4 halted not ready", {11'h0, array_ready}, 12'h0);
        pe_req = 1'b1;
        #1 check("R3 grant halted again", {11'h0, pe_grant}, 12'h0);
        pe_req = 1'b0;

        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule